// File: doc/BRIEF.md
# Shift Datapath with Arithmetic Carry

This block is the combinational shift stage of an integer execution unit. It takes a source operand, an amount operand and a small operation select. It produces a 64-bit result, a flag that says whether the select named a supported operation, and a 2-bit carry field. Three operations are supported: a logical left shift, a right shift that is either logical or arithmetic, and a combined step that sign-extends a 32-bit value to 64 bits and then shifts it left.

A word/doubleword mode flag selects the operand width and how many amount bits are used. An amount equal to or larger than the operand width is not wrapped. Such an amount fills the result with zeros, or with copies of the sign bit for an arithmetic right shift. The arithmetic right shift also reports whether any set bit was lost from a negative operand, in the same way a carry flag is set in an architectural carry register. A context word from the issue logic travels alongside the operands and comes out unchanged. The block holds no state, so its outputs follow its inputs in the same cycle.

Top module: `shc_shift_carry`

## Requirements
- R1: `op_sel` is encoded as 2'b00 = left shift, 2'b01 = right shift, 2'b10 = sign-extend-then-shift-left and 2'b11 = unsupported. `result_vld` is 1 for the first three codes. For 2'b11 it is 0, with `result` all zero and `carry_pair` 2'b00.
- R2: For left and right shifts, the amount is `amt_val[5:0]` when `word_mode` is 1 and `amt_val[6:0]` when it is 0. All higher bits of `amt_val` have no effect.
- R3: A left shift with `word_mode`=1 returns the low 32 bits of the source shifted left by the amount, with `result[63:32]` zero. Amounts from 32 to 63 give zero.
- R4: A left shift with `word_mode`=0 returns the low 64 bits of the source shifted left by the amount. Amounts from 64 to 127 give zero.
- R5: The right shift operand is `src_val[31:0]` when `word_mode`=1 and `src_val[63:0]` when `word_mode`=0. The operand is first extended to the full width: with its top bit when `signed_mode`=1, with zeros otherwise. The result is that value shifted right. An amount of 64 or more gives all zeros or all copies of the sign.
- R6: On a right shift with `signed_mode`=1, the carry is 1 exactly when the extended operand is negative and at least one 1 bit is shifted out. Both bits of `carry_pair` hold this value.
- R7: `carry_pair` is 2'b00 for left shifts, for the sign-extend-shift operation and for right shifts with `signed_mode`=0.
- R8: The sign-extend-shift operation sign-extends `src_val[31:0]` to 64 bits and shifts it left by `amt_val[5:0]`. `word_mode`, `signed_mode` and `amt_val[63:6]` have no effect on it.
- R9: `ctx_out` equals `ctx_in` for every operation code.
- R10: The block is purely combinational. Its outputs reflect the current inputs within the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_val | input | 64 | Source operand to be shifted |
| amt_val | input | 64 | Amount operand; only its low bits are used |
| op_sel | input | 2 | Operation select (see R1) |
| word_mode | input | 1 | 1 = 32-bit operation, 0 = 64-bit operation |
| signed_mode | input | 1 | 1 = arithmetic right shift |
| ctx_in | input | CTX_W (8) | Issue context carried with the operation |
| result | output | 64 | Shifted result |
| result_vld | output | 1 | Operation code is supported |
| carry_pair | output | 2 | Carry, duplicated into both bits |
| ctx_out | output | CTX_W (8) | Copy of ctx_in |

## Verification
The bench runs several kinds of directed cases on every operation:
- Amounts of zero, the width minus one, the width, and the largest encodable amount. These separate wrapping from zero fill or sign fill.
- Operands with only the top bit set, with all bits set, and with the 32-bit sign bit set. These show the difference between word and doubleword extension, and between arithmetic and logical fill.
- Negative operands where exactly the lost bits are zero or non-zero. These pin down the carry rule.
- Amount operands with garbage in their upper bits. These prove those bits are ignored.

A long random sweep with mixed modes, codes and context values then compares every output against a model that works in 128-bit signed arithmetic.

// File: rtl/shc_pkg.sv
package shc_pkg;
  typedef enum logic [1:0] {
    SHC_OP_LEFT  = 2'b00,
    SHC_OP_RIGHT = 2'b01,
    SHC_OP_SXLFT = 2'b10,
    SHC_OP_NONE  = 2'b11
  } shc_op_e;
endpackage

// File: rtl/shc_amount_pick.sv
module shc_amount_pick #(
  parameter int DATA_W = 64,
  localparam int SH_W  = $clog2(DATA_W),
  localparam int AMT_W = SH_W + 1
) (
  input  logic [DATA_W-1:0] amt_val,
  input  logic              narrow_amt,
  output logic [AMT_W-1:0]  amt_q
);
  logic unused_hi;
  assign unused_hi = ^amt_val[DATA_W-1:AMT_W];

  always_comb begin
    if (narrow_amt) amt_q = {1'b0, amt_val[SH_W-1:0]};
    else            amt_q = amt_val[AMT_W-1:0];
  end

  // R2: a narrowed amount never reaches the oversize range
  always_comb begin
    if (narrow_amt) begin
      amt_narrow_chk: assert (amt_q[AMT_W-1] == 1'b0) else $error("amt_narrow_chk");
    end
  end
endmodule

// File: rtl/shc_left_path.sv
module shc_left_path #(
  parameter int DATA_W = 64,
  localparam int HALF_W = DATA_W / 2,
  localparam int SH_W   = $clog2(DATA_W),
  localparam int AMT_W  = SH_W + 1
) (
  input  logic [DATA_W-1:0] src,
  input  logic [AMT_W-1:0]  amt,
  input  logic              word_mode,
  input  logic              sext_op,
  output logic [DATA_W-1:0] res
);
  function automatic logic [DATA_W-1:0] widen_half(input logic [DATA_W-1:0] v);
    return {{HALF_W{v[HALF_W-1]}}, v[HALF_W-1:0]};
  endfunction

  function automatic logic [DATA_W-1:0] shl_sat(input logic [DATA_W-1:0] v,
                                                input logic [AMT_W-1:0] a);
    if (a[AMT_W-1]) return '0;
    return v << a[SH_W-1:0];
  endfunction

  logic [DATA_W-1:0] opnd;
  logic [DATA_W-1:0] shifted;
  logic              oversize;
  logic              trim_high;

  always_comb begin
    opnd      = sext_op ? widen_half(src) : src;
    oversize  = amt[AMT_W-1];
    shifted   = shl_sat(opnd, amt);
    trim_high = word_mode && !sext_op;
    res       = trim_high ? {{HALF_W{1'b0}}, shifted[HALF_W-1:0]} : shifted;
  end

  always_comb begin
    // R3
    if (trim_high) begin
      word_hi_zero_chk: assert (res[DATA_W-1:HALF_W] == '0) else $error("word_hi_zero_chk");
    end
    // R4
    if (oversize) begin
      left_oversize_chk: assert (res == '0) else $error("left_oversize_chk");
    end
  end
endmodule

// File: rtl/shc_right_path.sv
module shc_right_path #(
  parameter int DATA_W = 64,
  localparam int HALF_W = DATA_W / 2,
  localparam int SH_W   = $clog2(DATA_W),
  localparam int AMT_W  = SH_W + 1
) (
  input  logic [DATA_W-1:0] src,
  input  logic [AMT_W-1:0]  amt,
  input  logic              word_mode,
  input  logic              signed_mode,
  output logic [DATA_W-1:0] res,
  output logic              carry
);
  function automatic logic [DATA_W-1:0] shr_fill(input logic [DATA_W-1:0] v,
                                                 input logic f,
                                                 input logic [AMT_W-1:0] a);
    logic signed [DATA_W:0] wide;
    logic signed [DATA_W:0] moved;
    if (a[AMT_W-1]) return {DATA_W{f}};
    wide  = {f, v};
    moved = wide >>> a[SH_W-1:0];
    return moved[DATA_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] low_mask(input logic [AMT_W-1:0] a);
    if (a[AMT_W-1]) return '1;
    return (DATA_W'(1) << a[SH_W-1:0]) - DATA_W'(1);
  endfunction

  logic              fill_bit;
  logic              oversize;
  logic              lost_any;
  logic [DATA_W-1:0] opnd;

  always_comb begin
    fill_bit = signed_mode && (word_mode ? src[HALF_W-1] : src[DATA_W-1]);
    opnd     = word_mode ? {{HALF_W{fill_bit}}, src[HALF_W-1:0]} : src;
    oversize = amt[AMT_W-1];
    lost_any = |(opnd & low_mask(amt));
    carry    = fill_bit && lost_any;
    res      = shr_fill(opnd, fill_bit, amt);
  end

  always_comb begin
    // R6
    if (carry) begin
      carry_neg_chk: assert (res[DATA_W-1] == 1'b1) else $error("carry_neg_chk");
    end
    // R7
    if (!signed_mode) begin
      logical_no_carry_chk: assert (!carry) else $error("logical_no_carry_chk");
    end
    // R5
    if (oversize && !fill_bit) begin
      right_zero_fill_chk: assert (res == '0) else $error("right_zero_fill_chk");
    end
  end
endmodule

// File: rtl/shc_shift_carry.sv
module shc_shift_carry #(
  parameter int DATA_W = 64,
  parameter int CTX_W  = 8
) (
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] amt_val,
  input  logic [1:0]        op_sel,
  input  logic              word_mode,
  input  logic              signed_mode,
  input  logic [CTX_W-1:0]  ctx_in,
  output logic [DATA_W-1:0] result,
  output logic              result_vld,
  output logic [1:0]        carry_pair,
  output logic [CTX_W-1:0]  ctx_out
);
  import shc_pkg::*;
  localparam int SH_W  = $clog2(DATA_W);
  localparam int AMT_W = SH_W + 1;

  shc_op_e           op;
  logic              is_sext;
  logic              narrow_amt;
  logic [AMT_W-1:0]  amt_q;
  logic [DATA_W-1:0] left_res;
  logic [DATA_W-1:0] right_res;
  logic              right_carry;

  assign op         = shc_op_e'(op_sel);
  assign is_sext    = (op == SHC_OP_SXLFT);
  assign narrow_amt = word_mode || is_sext;

  shc_amount_pick #(.DATA_W(DATA_W)) u_amt (
    .amt_val    (amt_val),
    .narrow_amt (narrow_amt),
    .amt_q      (amt_q)
  );

  shc_left_path #(.DATA_W(DATA_W)) u_left (
    .src       (src_val),
    .amt       (amt_q),
    .word_mode (word_mode),
    .sext_op   (is_sext),
    .res       (left_res)
  );

  shc_right_path #(.DATA_W(DATA_W)) u_right (
    .src         (src_val),
    .amt         (amt_q),
    .word_mode   (word_mode),
    .signed_mode (signed_mode),
    .res         (right_res),
    .carry       (right_carry)
  );

  always_comb begin
    result     = '0;
    result_vld = 1'b1;
    carry_pair = 2'b00;
    unique case (op)
      SHC_OP_LEFT, SHC_OP_SXLFT: result = left_res;
      SHC_OP_RIGHT: begin
        result     = right_res;
        carry_pair = {2{right_carry}};
      end
      default: result_vld = 1'b0;
    endcase
  end

  assign ctx_out = ctx_in;

  always_comb begin
    // R1
    if (!result_vld) begin
      idle_quiet_chk: assert (result == '0 && carry_pair == 2'b00) else $error("idle_quiet_chk");
    end
    // R7
    if (carry_pair != 2'b00) begin
      carry_source_chk: assert (op_sel == 2'b01 && signed_mode) else $error("carry_source_chk");
    end
  end
endmodule

// File: tb/shc_shift_carry_tb.sv
module shc_shift_carry_tb_top;
  localparam int CTX_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [63:0]      src_val, amt_val, result;
  logic [1:0]       op_sel, carry_pair;
  logic             word_mode, signed_mode, result_vld;
  logic [CTX_W-1:0] ctx_in, ctx_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  shc_shift_carry #(.DATA_W(64), .CTX_W(CTX_W)) dut_i (
    .src_val(src_val), .amt_val(amt_val), .op_sel(op_sel),
    .word_mode(word_mode), .signed_mode(signed_mode), .ctx_in(ctx_in),
    .result(result), .result_vld(result_vld), .carry_pair(carry_pair),
    .ctx_out(ctx_out)
  );

  // Behavioural reference in 128-bit arithmetic
  task automatic model(input logic [63:0] s, input logic [63:0] a, input logic [1:0] op,
                       input logic wm, input logic sg,
                       output logic [63:0] r, output logic v, output logic [1:0] c);
    logic signed [127:0] x, y;
    int k;
    r = 64'd0; v = 1'b1; c = 2'b00;
    case (op)
      2'b00: begin
        k = wm ? int'(a[5:0]) : int'(a[6:0]);
        x = {64'd0, s} << k;
        r = wm ? {32'd0, x[31:0]} : x[63:0];
      end
      2'b01: begin
        k = wm ? int'(a[5:0]) : int'(a[6:0]);
        if (wm) x = sg ? {{96{s[31]}}, s[31:0]} : {96'd0, s[31:0]};
        else    x = sg ? {{64{s[63]}}, s} : {64'd0, s};
        y = sg ? (x >>> k) : (x >> k);
        r = y[63:0];
        if (sg && x < 0 && ((y <<< k) != x)) c = 2'b11;
      end
      2'b10: begin
        k = int'(a[5:0]);
        x = {{96{s[31]}}, s[31:0]};
        x = x << k;
        r = x[63:0];
      end
      default: v = 1'b0;
    endcase
  endtask

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Drive on the falling edge; outputs settle combinationally (R10) and are
  // sampled 1 ns later, within the same cycle.
  task automatic run_vec(input logic [63:0] s, input logic [63:0] a, input logic [1:0] op,
                         input logic wm, input logic sg, input logic [CTX_W-1:0] cx,
                         input string tag_in);
    logic [63:0] er; logic ev; logic [1:0] ec;
    string tag, ctag;
    @(negedge clk);
    src_val = s; amt_val = a; op_sel = op; word_mode = wm; signed_mode = sg; ctx_in = cx;
    #1;
    model(s, a, op, wm, sg, er, ev, ec);
    if (tag_in != "") tag = tag_in;
    else case (op)
      2'b00: tag = wm ? "R3" : "R4";
      2'b01: tag = "R5";
      2'b10: tag = "R8";
      default: tag = "R1";
    endcase
    ctag = (op == 2'b01 && sg) ? "R6" : "R7";
    chk(tag, "result", result, er);
    chk("R1", "result_vld", 64'(result_vld), 64'(ev));
    chk(ctag, "carry_pair", 64'(carry_pair), 64'(ec));
    chk("R9", "ctx_out", 64'(ctx_out), 64'(cx));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    src_val = '0; amt_val = '0; op_sel = 2'b11; word_mode = 0; signed_mode = 0; ctx_in = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: reset state with the unsupported code applied
    chk("R1", "reset result_vld", 64'(result_vld), 64'd0);
    chk("R1", "reset result", result, 64'd0);

    // R1 unsupported code with busy inputs
    run_vec(64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 2'b11, 0, 1, 8'h5A, "R1");
    // R3 word left, boundary amounts
    run_vec(64'hDEAD_BEEF_8000_0001, 64'd0,  2'b00, 1, 0, 8'h01, "R3");
    run_vec(64'hDEAD_BEEF_8000_0001, 64'd31, 2'b00, 1, 0, 8'h02, "R3");
    run_vec(64'hDEAD_BEEF_8000_0001, 64'd32, 2'b00, 1, 0, 8'h03, "R3");
    run_vec(64'hDEAD_BEEF_8000_0001, 64'd63, 2'b00, 1, 0, 8'h04, "R3");
    // R4 doubleword left
    run_vec(64'h8000_0000_0000_0001, 64'd63,  2'b00, 0, 0, 8'h05, "R4");
    run_vec(64'h8000_0000_0000_0001, 64'd64,  2'b00, 0, 0, 8'h06, "R4");
    run_vec(64'hFFFF_FFFF_FFFF_FFFF, 64'd127, 2'b00, 0, 0, 8'h07, "R4");
    // R2 upper amount bits ignored
    run_vec(64'h0000_0000_0000_00F0, 64'hFFFF_FFFF_FFFF_FF84, 2'b00, 0, 0, 8'h08, "R2");
    run_vec(64'h0000_0000_0000_00F0, 64'hABCD_0000_0000_00C4, 2'b00, 1, 0, 8'h09, "R2");
    run_vec(64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FF81, 2'b01, 0, 1, 8'h0A, "R2");
    // R5 right shift fills
    run_vec(64'h0000_0000_8000_0000, 64'd4,   2'b01, 1, 1, 8'h0B, "R5");
    run_vec(64'h0000_0000_8000_0000, 64'd4,   2'b01, 1, 0, 8'h0C, "R5");
    run_vec(64'hFFFF_FFFF_7FFF_FFFF, 64'd63,  2'b01, 1, 1, 8'h0D, "R5");
    run_vec(64'h8000_0000_0000_0000, 64'd64,  2'b01, 0, 1, 8'h0E, "R5");
    run_vec(64'h8000_0000_0000_0000, 64'd100, 2'b01, 0, 0, 8'h0F, "R5");
    // R6 carry: negative with lost ones vs lost zeros
    run_vec(64'hFFFF_FFFF_FFFF_FFF0, 64'd4, 2'b01, 0, 1, 8'h10, "R6");
    run_vec(64'hFFFF_FFFF_FFFF_FFF0, 64'd5, 2'b01, 0, 1, 8'h11, "R6");
    run_vec(64'h0000_0000_8000_0001, 64'd1, 2'b01, 1, 1, 8'h12, "R6");
    run_vec(64'h0000_0000_8000_0000, 64'd40, 2'b01, 1, 1, 8'h13, "R6");
    run_vec(64'h7FFF_FFFF_FFFF_FFFF, 64'd8, 2'b01, 0, 1, 8'h14, "R6");
    // R7 no carry on logical right, left or sign-extend-shift
    run_vec(64'hFFFF_FFFF_FFFF_FFFF, 64'd8, 2'b01, 0, 0, 8'h15, "R7");
    run_vec(64'hFFFF_FFFF_FFFF_FFFF, 64'd8, 2'b00, 0, 1, 8'h16, "R7");
    run_vec(64'hFFFF_FFFF_FFFF_FFFF, 64'd8, 2'b10, 1, 1, 8'h17, "R7");
    // R8 sign-extend-shift, modes and upper amount bits ignored
    run_vec(64'h1234_5678_8000_0001, 64'd0,  2'b10, 0, 0, 8'h18, "R8");
    run_vec(64'h1234_5678_8000_0001, 64'hFF00_0000_0000_0044, 2'b10, 1, 1, 8'h19, "R8");
    run_vec(64'h1234_5678_4000_0001, 64'd63, 2'b10, 1, 0, 8'h1A, "R8");
    // R10 back-to-back changes seen in the same cycle
    run_vec(64'h1, 64'd1, 2'b00, 0, 0, 8'h1B, "R10");
    run_vec(64'h1, 64'd2, 2'b00, 0, 0, 8'h1C, "R10");

    // Random sweep (R1..R9)
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] s, a;
      s = {$urandom(), $urandom()};
      if (i % 4 == 1) s[31] = 1'b1;
      if (i % 4 == 2) s[63] = 1'b1;
      a = {$urandom(), $urandom()};
      if (i % 3 == 0) a[63:7] = '0;
      run_vec(s, a, 2'($urandom()), 1'($urandom()), 1'($urandom()), CTX_W'($urandom()), "");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule